// File: doc/BRIEF.md
# Run-time Reconfigurable Link Permutation for an 8x8 Delta Network

This block carries the inter-stage links of an eight-port delta network built from 2x2 switches. The network has three switch stages with four switches each, and one link stage sits in front of each switch stage. Every link stage moves the word on input link `i` to output link `p(i)`. Here `p` is a bit permutation of the 3-bit link index: shuffle, butterfly, baseline or identity. The topology currently in force decides which permutation each link stage applies. The wiring is purely combinational.

A manager changes the topology at run time. It raises `cfg_req` for one cycle with a topology code on `cfg_sel`. The block then drops `inject_ok` so that sources stop injecting. It waits a fixed drain window so the stages can empty. It then switches the active topology in a single cycle and raises `inject_ok` again. A request that arrives while a change is already in progress is held in a one-entry slot. It is started on the next return to the running state. If several requests arrive in that time, the latest one wins.

Top module: `rpn_reconfig_net`

## Requirements
- R1: After reset, `cfg_cur` reads 0 (the Omega topology) and `inject_ok` is high.
- R2: Topology code 0 (Omega) applies the perfect shuffle in all three link stages. The word on input link i leaves on link d, where d is i rotated left by one bit over 3 bits (bit 2 moves to bit 0).
- R3: Topology code 1 (butterfly) applies identity in link stage 0. It applies butterfly k=2 in link stage 1 and butterfly k=1 in link stage 2. Butterfly k exchanges index bit k with bit 0 and keeps every other bit.
- R4: Topology code 2 (baseline) applies identity in link stage 0. It applies baseline k=2 in link stage 1 and baseline k=1 in link stage 2. Baseline k rotates index bits k..0 right by one, so bit 0 moves to bit k, and keeps the higher bits.
- R5: Topology code 3 (straight) applies identity in every link stage, so output link i carries input link i.
- R6: In every topology and every link stage the mapping is a bijection: each output link carries exactly one input link.
- R7: A request accepted in the running state holds `inject_ok` low from the next cycle for DRAIN_CYC+1 cycles (3 drain cycles plus 1 switch cycle by default).
- R8: `cfg_cur` and the wiring keep the old topology through the drain window. Both take the requested code in the same cycle in which `inject_ok` returns high.
- R9: A request raised while a change is in progress is held. It starts its own drain one cycle after the running state resumes and ends with its code active.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_req | input | 1 | One-cycle topology change request |
| cfg_sel | input | 2 | Requested topology code: 0 Omega, 1 butterfly, 2 baseline, 3 straight |
| lnk_in | input | 192 | Link words entering the link stages; stage s, link i at bits (s*8+i)*8 +: 8 |
| lnk_out | output | 192 | Permuted link words; same layout as `lnk_in` |
| inject_ok | output | 1 | High when sources may inject traffic |
| cfg_cur | output | 2 | Topology code currently wired |

## Verification
A wrong permutation selection shows up on `lnk_out` in the same cycle. Link words land on the wrong index or collide, and the bench sees this as soon as it compares every link of every stage. A sequencer stuck in, or leaving, the drain state at the wrong time changes the `inject_ok` pattern within one cycle of the miscount. An early or late switch makes `cfg_cur` change in a cycle other than the one where `inject_ok` rises. A lost held request leaves `cfg_cur` on the first code once the second change should have finished, about ten cycles after the first request.

// File: rtl/rpn_pkg.sv
package rpn_pkg;

  typedef enum logic [1:0] {
    TOPO_OMEGA    = 2'd0,
    TOPO_BFLY     = 2'd1,
    TOPO_BASE     = 2'd2,
    TOPO_STRAIGHT = 2'd3
  } topo_e;

  typedef enum logic [1:0] {
    PK_IDENT = 2'd0,
    PK_SHUF  = 2'd1,
    PK_BFLY  = 2'd2,
    PK_BASE  = 2'd3
  } pkind_e;

  typedef enum logic [1:0] {
    ST_RUN    = 2'd0,
    ST_DRAIN  = 2'd1,
    ST_SWITCH = 2'd2
  } rc_state_e;

  // Which permutation kind a topology uses in front of switch stage s.
  function automatic pkind_e stage_kind(topo_e t, int s);
    pkind_e r;
    case (t)
      TOPO_OMEGA:    r = PK_SHUF;
      TOPO_STRAIGHT: r = PK_IDENT;
      TOPO_BFLY:     r = (s == 0) ? PK_IDENT : PK_BFLY;
      default:       r = (s == 0) ? PK_IDENT : PK_BASE;
    endcase
    return r;
  endfunction

  // Bit order parameter of the permutation in link stage s.
  function automatic int stage_k(int iw, int s);
    return iw - s;
  endfunction

  // Source bit feeding destination bit j of the mapped index.
  function automatic int src_bit(pkind_e kind, int k, int iw, int j);
    int r;
    case (kind)
      PK_SHUF: r = (j == 0) ? iw - 1 : j - 1;
      PK_BFLY: r = (j == k) ? 0 : ((j == 0) ? k : j);
      PK_BASE: r = (j < k) ? j + 1 : ((j == k) ? 0 : j);
      default: r = j;
    endcase
    return r;
  endfunction

  // Destination link index of source link x.
  function automatic int pm_map(pkind_e kind, int k, int iw, int x);
    int y;
    y = 0;
    for (int j = 0; j < iw; j++) begin
      y = y | (((x >> src_bit(kind, k, iw, j)) & 1) << j);
    end
    return y;
  endfunction

endpackage

// File: rtl/rpn_link_stage.sv
module rpn_link_stage
  import rpn_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int IDX_W  = 3,
  parameter int STAGE  = 0,
  localparam int LINKS = 1 << IDX_W,
  localparam int BUS_W = LINKS * DATA_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  topo_e            topo,
  input  logic [BUS_W-1:0] din,
  output logic [BUS_W-1:0] dout
);

  logic [LINKS-1:0] hit;   // output links that received a source

  always_comb begin
    dout = '0;
    hit  = '0;
    for (int i = 0; i < LINKS; i++) begin
      logic [IDX_W-1:0] dst;
      dst = IDX_W'(pm_map(stage_kind(topo, STAGE), stage_k(IDX_W, STAGE), IDX_W, i));
      dout[dst*DATA_W +: DATA_W] = din[i*DATA_W +: DATA_W];
      hit[dst] = 1'b1;
    end
  end

  AST_BIJECTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(hit) == LINKS);  // R6

endmodule

// File: rtl/rpn_recfg_ctrl.sv
module rpn_recfg_ctrl
  import rpn_pkg::*;
#(
  parameter int DRAIN_CYC = 3,
  localparam int CW = $clog2(DRAIN_CYC + 1)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_req,
  input  logic [1:0] cfg_sel,
  output topo_e      active,
  output logic       inject_ok
);

  rc_state_e       st;
  logic [CW-1:0]   cnt;
  topo_e           target;
  logic            pend;
  topo_e           pend_sel;

  // Named internal events
  logic  run, start, hold_req, drain_done, switch_fire;
  topo_e start_sel;

  assign run         = (st == ST_RUN);
  assign start       = run && (cfg_req || pend);
  assign start_sel   = cfg_req ? topo_e'(cfg_sel) : pend_sel;
  assign hold_req    = cfg_req && !run;
  assign drain_done  = (st == ST_DRAIN) && (cnt == CW'(DRAIN_CYC - 1));
  assign switch_fire = (st == ST_SWITCH);
  assign inject_ok   = run;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= ST_RUN;
      cnt    <= '0;
      target <= TOPO_OMEGA;
      active <= TOPO_OMEGA;
    end else begin
      case (st)
        ST_RUN: if (start) begin
          st     <= ST_DRAIN;
          target <= start_sel;
          cnt    <= '0;
        end
        ST_DRAIN: begin
          if (drain_done) st <= ST_SWITCH;
          else            cnt <= cnt + 1'b1;
        end
        ST_SWITCH: begin
          active <= target;
          st     <= ST_RUN;
        end
        default: st <= ST_RUN;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend     <= 1'b0;
      pend_sel <= TOPO_OMEGA;
    end else if (start) begin
      pend <= 1'b0;
    end else if (hold_req) begin
      pend     <= 1'b1;
      pend_sel <= topo_e'(cfg_sel);
    end
  end

  AST_REQ_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !inject_ok);  // R7
  AST_CFG_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !switch_fire |=> $stable(active));  // R8
  AST_RESUME: assert property (@(posedge clk) disable iff (!rst_n)
    switch_fire |=> (inject_ok && active == $past(target)));  // R8
  AST_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    hold_req |=> pend);  // R9

endmodule

// File: rtl/rpn_reconfig_net.sv
module rpn_reconfig_net
  import rpn_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int IDX_W     = 3,
  parameter int DRAIN_CYC = 3,
  localparam int LINKS    = 1 << IDX_W,
  localparam int STAGES   = IDX_W,
  localparam int SW       = LINKS * DATA_W,
  localparam int BUS_W    = STAGES * SW
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_req,
  input  logic [1:0]       cfg_sel,
  input  logic [BUS_W-1:0] lnk_in,
  output logic [BUS_W-1:0] lnk_out,
  output logic             inject_ok,
  output logic [1:0]       cfg_cur
);

  topo_e active;

  rpn_recfg_ctrl #(.DRAIN_CYC(DRAIN_CYC)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_req   (cfg_req),
    .cfg_sel   (cfg_sel),
    .active    (active),
    .inject_ok (inject_ok)
  );

  assign cfg_cur = active;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    rpn_link_stage #(.DATA_W(DATA_W), .IDX_W(IDX_W), .STAGE(s)) u_lnk (
      .clk   (clk),
      .rst_n (rst_n),
      .topo  (active),
      .din   (lnk_in[s*SW +: SW]),
      .dout  (lnk_out[s*SW +: SW])
    );
  end

endmodule

// File: tb/rpn_reconfig_net_test.sv
module rpn_reconfig_net_test;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         cfg_req = 1'b0;
  logic [1:0]   cfg_sel = 2'd0;
  logic [191:0] lnk_in;
  logic [191:0] lnk_out;
  logic         inject_ok;
  logic [1:0]   cfg_cur;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;  // 50 MHz

  rpn_reconfig_net uut (
    .clk(clk), .rst_n(rst_n), .cfg_req(cfg_req), .cfg_sel(cfg_sel),
    .lnk_in(lnk_in), .lnk_out(lnk_out), .inject_ok(inject_ok), .cfg_cur(cfg_cur)
  );

  // Each input word is tagged with its stage and link: s*16 + i
  initial begin
    for (int s = 0; s < 3; s++)
      for (int i = 0; i < 8; i++)
        lnk_in[(s*8+i)*8 +: 8] = 8'(s*16 + i);
  end

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Expected destination, written as arithmetic on the index
  function automatic int exp_dst(int cfg, int s, int i);
    int k, m, lo;
    if (cfg == 0) return ((i << 1) & 6) | (i >> 2);
    if (cfg == 3 || s == 0) return i;
    k = 3 - s;
    if (cfg == 1)
      return (i & ~((1 << k) | 1)) | ((i & 1) << k) | ((i >> k) & 1);
    m  = (2 << k) - 1;
    lo = i & m;
    return (i & ~m) | (lo >> 1) | ((lo & 1) << k);
  endfunction

  task automatic check_wiring(int cfg, string req);
    for (int s = 0; s < 3; s++) begin
      int bad_act, bad_exp;
      bit ok;
      ok = 1;
      bad_act = 0;
      bad_exp = 0;
      for (int i = 0; i < 8; i++) begin
        int d, got;
        d   = exp_dst(cfg, s, i);
        got = int'(lnk_out[(s*8+d)*8 +: 8]);
        if (ok && got != s*16 + i) begin
          ok = 0;
          bad_act = got;
          bad_exp = s*16 + i;
        end
      end
      check(ok, req, bad_act, bad_exp);
    end
  endtask

  task automatic t_reset;
    @(negedge clk);
    check(cfg_cur == 2'd0, "R1 cfg", int'(cfg_cur), 0);
    check(inject_ok == 1'b1, "R1 inject", int'(inject_ok), 1);
    check_wiring(0, "R2 omega");
  endtask

  task automatic t_reconfig(int sel, string req);
    int old;
    @(negedge clk);
    old = int'(cfg_cur);
    cfg_req = 1'b1;
    cfg_sel = 2'(sel);
    for (int k = 1; k <= 5; k++) begin
      @(negedge clk);
      cfg_req = 1'b0;
      if (k < 5) begin
        check(inject_ok == 1'b0, "R7 inject low", int'(inject_ok), 0);
        check(int'(cfg_cur) == old, "R8 cfg held", int'(cfg_cur), old);
      end else begin
        check(inject_ok == 1'b1, "R7 inject back", int'(inject_ok), 1);
        check(int'(cfg_cur) == sel, "R8 cfg new", int'(cfg_cur), sel);
      end
    end
    check_wiring(sel, req);
  endtask

  task automatic t_held(int sel_a, int sel_b);
    @(negedge clk);
    cfg_req = 1'b1; cfg_sel = 2'(sel_a);
    @(negedge clk);
    cfg_req = 1'b0;
    @(negedge clk);                       // in drain
    cfg_req = 1'b1; cfg_sel = 2'(sel_b);
    @(negedge clk);
    cfg_req = 1'b0;
    repeat (2) @(negedge clk);            // after first change completes
    check(int'(cfg_cur) == sel_a, "R9 first cfg", int'(cfg_cur), sel_a);
    check(inject_ok == 1'b1, "R9 run gap", int'(inject_ok), 1);
    check_wiring(sel_a, "R4 baseline");
    @(negedge clk);
    check(inject_ok == 1'b0, "R9 second drain", int'(inject_ok), 0);
    repeat (3) @(negedge clk);
    check(inject_ok == 1'b0, "R9 still draining", int'(inject_ok), 0);
    @(negedge clk);
    check(int'(cfg_cur) == sel_b, "R9 held cfg", int'(cfg_cur), sel_b);
    check(inject_ok == 1'b1, "R9 resumed", int'(inject_ok), 1);
    check_wiring(sel_b, "R5 straight");
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_reconfig(1, "R3 butterfly R6");
    t_held(2, 3);
    t_reconfig(0, "R2 omega again R6");
    repeat (2) @(negedge clk);
    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

endmodule